// File: doc/BRIEF.md
# Configuration Image Header Parser

This block reads the header of a programmable-logic configuration image as a plain byte stream. It works out two things: the stream offset where the bitstream payload begins, and how many payload bytes follow. Bytes arrive on a valid/ready interface. The position of each byte is never sent; the block keeps its own running index, which starts at zero after reset.

The block works in four steps as the bytes go by:
- It reads a few fields at fixed positions.
- It uses the header length it has read to find the start of a table of block records.
- It walks that table to find the payload offset and the offset of a size table.
- It unpacks the size table, in which each component size is a 22-bit field with no gap to its neighbour, and adds the sizes up.

When all the information is present, `done` pulses once. The payload offset and the length are then held on the outputs, and the stream is back-pressured. When the header cannot be parsed, `err` rises and stays high.

Top module: `cfg_hdr_parser`

## Requirements
- R1: After reset, `s_ready` is high, `done` and `err` are low, `bs_start` and `payload_len` are zero, and the next accepted byte has index 0.
- R2: The byte at index 24 is the base header length. A base length below 71 raises `err`, and `done` never pulses.
- R3: The byte at index (base length − 1) is the number of block records. A record count of zero raises `err`.
- R4: Records are 9 bytes long and follow one another, starting at the index equal to the base length. In each record, byte 0 is the block ID and bytes 1 to 4 hold a 32-bit offset, least significant byte first. The offset of a record with ID 8 is the payload start, reported on `bs_start`.
- R5: The offset of a record with ID 5 is the start index of the size table. A record with any other ID changes neither offset.
- R6: The record walk stops as soon as both offsets are known, so any later record has no effect on `bs_start`.
- R7: If either offset is still unknown after the last record, `err` rises and `done` never pulses.
- R8: The component count is a 16-bit value at indices 55 (low byte) and 56 (high byte). Component i occupies bits 22i to 22i+21 of the size table, counted from bit 0 of its first byte upward. `payload_len` equals 16 times the sum of all component sizes.
- R9: A component count of zero gives `done` with a `payload_len` of zero, as soon as both offsets are known.
- R10: Consider the index of the last offset byte of the ID-5 record. If the size-table offset is less than or equal to that index, `err` rises. An offset one greater than that index is accepted.
- R11: `done` is high for a single cycle. From that cycle on, `s_ready` is low and the outputs hold their values. `err`, once raised, stays high and keeps `s_ready` low.
- R12: While the walk is still running, a later record with an ID already seen replaces the earlier offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input byte valid |
| s_data | input | 8 | Input byte |
| s_ready | output | 1 | Byte accepted when high together with s_valid |
| bs_start | output | 32 | Stream index where the bitstream payload begins |
| payload_len | output | 44 | Payload length in bytes |
| done | output | 1 | One-cycle strobe: results are valid |
| err | output | 1 | Sticky header error flag |

## Verification
The size-table tests use sizes whose 22-bit fields cross byte edges at every possible bit phase, including an all-ones field. A slip of one bit in the unpacking shift would corrupt every field after the first and give the wrong length.

Other tests target the record walk:
- A bitstream record placed after both offsets are known catches a design that keeps scanning, because it would report the later offset.
- A repeated ID before the walk ends catches a design that keeps the first offset it sees.
- A size table that starts exactly at, or exactly one after, the index of its record's last offset byte catches a comparison that is off by one in either direction.

Error images cover a base length that is too short, a record count of zero and a missing ID. Each of these must leave `done` silent and hold `err` high.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  // Record walk progress
  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,   // waiting for the record count byte
    SC_WALK = 2'd1,   // stepping through records
    SC_HIT  = 2'd2,   // both offsets found
    SC_MISS = 2'd3    // records exhausted or count was zero
  } scan_state_t;

  // Component count field is two bytes wide
  localparam int CNT_W = 16;

endpackage

// File: rtl/cfg_hdr_fields.sv
module cfg_hdr_fields
  import cfg_hdr_pkg::*;
#(
  parameter int OFF_W   = 32,
  parameter int LEN_POS = 24,
  parameter int CNT_POS = 55,
  parameter int MIN_HDR = 71
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [7:0]       data,
  input  logic [OFF_W-1:0] idx,
  output logic [7:0]       base_len,
  output logic             base_good,
  output logic             base_bad,
  output logic [CNT_W-1:0] comp_cnt,
  output logic             cnt_ok
);

  localparam logic [OFF_W-1:0] LEN_AT  = OFF_W'(LEN_POS);
  localparam logic [OFF_W-1:0] CNT_LO  = OFF_W'(CNT_POS);
  localparam logic [OFF_W-1:0] CNT_HI  = OFF_W'(CNT_POS + 1);
  localparam logic [7:0]       HDR_MIN = 8'(MIN_HDR);

  logic base_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_len <= '0;
      base_ok  <= 1'b0;
      comp_cnt <= '0;
      cnt_ok   <= 1'b0;
    end else if (take) begin
      if (idx == LEN_AT) begin
        base_len <= data;
        base_ok  <= 1'b1;
      end
      if (idx == CNT_LO) comp_cnt[7:0] <= data;
      if (idx == CNT_HI) begin
        comp_cnt[15:8] <= data;
        cnt_ok         <= 1'b1;
      end
    end
  end

  assign base_bad  = base_ok && (base_len < HDR_MIN);
  assign base_good = base_ok && !(base_len < HDR_MIN);

endmodule

// File: rtl/cfg_lut_scan.sv
module cfg_lut_scan
  import cfg_hdr_pkg::*;
#(
  parameter int OFF_W     = 32,
  parameter int REC_BYTES = 9,
  parameter int ID_BS     = 8,
  parameter int ID_TBL    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [7:0]       data,
  input  logic [OFF_W-1:0] idx,
  input  logic [7:0]       base_len,
  input  logic             base_good,
  output scan_state_t      state,
  output logic [OFF_W-1:0] bs_off,
  output logic [OFF_W-1:0] tbl_off,
  output logic             tbl_known,
  output logic             tbl_bad
);

  localparam int OFF_BYTES = OFF_W / 8;
  localparam int POS_W     = $clog2(REC_BYTES);
  localparam logic [POS_W-1:0] P_ID   = '0;
  localparam logic [POS_W-1:0] P_LAST = POS_W'(OFF_BYTES);
  localparam logic [POS_W-1:0] P_END  = POS_W'(REC_BYTES - 1);

  logic [OFF_W-1:0] rec_at;
  logic [OFF_W-1:0] off_sr;
  logic [OFF_W-1:0] full_off;
  logic [7:0]       nrec, rcnt, id_r;
  logic [POS_W-1:0] pos;
  logic             have_bs;
  logic             is_bs, is_tbl, got_both;

  assign rec_at   = {{(OFF_W-8){1'b0}}, base_len} - {{(OFF_W-1){1'b0}}, 1'b1};
  assign full_off = {data, off_sr[OFF_W-1:8]};
  assign is_bs    = (id_r == 8'(ID_BS));
  assign is_tbl   = (id_r == 8'(ID_TBL));
  assign got_both = (have_bs || is_bs) && (tbl_known || is_tbl);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SC_IDLE;
      nrec      <= '0;
      rcnt      <= '0;
      id_r      <= '0;
      pos       <= '0;
      off_sr    <= '0;
      bs_off    <= '0;
      tbl_off   <= '0;
      have_bs   <= 1'b0;
      tbl_known <= 1'b0;
      tbl_bad   <= 1'b0;
    end else if (take) begin
      case (state)
        SC_IDLE: begin
          if (base_good && idx == rec_at) begin
            nrec  <= data;
            rcnt  <= '0;
            pos   <= P_ID;
            state <= (data == 8'd0) ? SC_MISS : SC_WALK;
          end
        end
        SC_WALK: begin
          if (pos == P_ID) id_r <= data;
          else if (pos <= P_LAST) off_sr <= full_off;
          if (pos == P_LAST) begin
            if (is_bs) begin
              bs_off  <= full_off;
              have_bs <= 1'b1;
            end
            if (is_tbl) begin
              tbl_off   <= full_off;
              tbl_known <= 1'b1;
              tbl_bad   <= (full_off <= idx);
            end
            if (got_both)                      state <= SC_HIT;
            else if (rcnt == nrec - 8'd1)      state <= SC_MISS;
          end
          if (pos == P_END) begin
            pos  <= P_ID;
            rcnt <= rcnt + 8'd1;
          end else begin
            pos <= pos + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cfg_size_unpack.sv
module cfg_size_unpack
  import cfg_hdr_pkg::*;
#(
  parameter int OFF_W  = 32,
  parameter int SIZE_W = 22,
  parameter int SUM_W  = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [7:0]       data,
  input  logic [OFF_W-1:0] idx,
  input  logic             tbl_known,
  input  logic [OFF_W-1:0] tbl_off,
  input  logic [CNT_W-1:0] comp_cnt,
  input  logic             cnt_ok,
  output logic [SUM_W-1:0] sum,
  output logic             complete
);

  localparam int ACC_W = SIZE_W + 7;
  localparam int NB_W  = $clog2(ACC_W + 1);
  localparam logic [NB_W-1:0] NB_SIZE = NB_W'(SIZE_W);
  localparam logic [NB_W-1:0] NB_BYTE = NB_W'(8);

  logic [ACC_W-1:0] acc, wide;
  logic [NB_W-1:0]  nb, nb_sum;
  logic [CNT_W-1:0] emitted;
  logic             feed;

  assign feed   = take && tbl_known && (idx >= tbl_off) && (emitted != comp_cnt);
  assign wide   = acc | (ACC_W'(data) << nb);
  assign nb_sum = nb + NB_BYTE;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      nb      <= '0;
      emitted <= '0;
      sum     <= '0;
    end else if (feed) begin
      if (nb_sum >= NB_SIZE) begin
        sum     <= sum + SUM_W'(wide[SIZE_W-1:0]);
        acc     <= wide >> SIZE_W;
        nb      <= nb_sum - NB_SIZE;
        emitted <= emitted + 1'b1;
      end else begin
        acc <= wide;
        nb  <= nb_sum;
      end
    end
  end

  assign complete = cnt_ok && (emitted == comp_cnt);

endmodule

// File: rtl/cfg_hdr_parser.sv
module cfg_hdr_parser
  import cfg_hdr_pkg::*;
#(
  parameter int OFF_W      = 32,
  parameter int SIZE_W     = 22,
  parameter int SUM_W      = 40,
  parameter int FRAME_LOG2 = 4,
  parameter int LEN_POS    = 24,
  parameter int CNT_POS    = 55,
  parameter int MIN_HDR    = 71,
  parameter int REC_BYTES  = 9,
  parameter int ID_BS      = 8,
  parameter int ID_TBL     = 5,
  localparam int LEN_W     = SUM_W + FRAME_LOG2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  output logic             s_ready,
  output logic [OFF_W-1:0] bs_start,
  output logic [LEN_W-1:0] payload_len,
  output logic             done,
  output logic             err
);

  logic [OFF_W-1:0] idx;
  logic             take, fin;
  logic [7:0]       base_len;
  logic             base_good, base_bad, cnt_ok, tbl_known, tbl_bad, complete;
  logic [CNT_W-1:0] comp_cnt;
  logic [OFF_W-1:0] bs_off, tbl_off;
  logic [SUM_W-1:0] sum;
  scan_state_t      scan_st;
  logic             err_now, done_now;

  assign s_ready = !fin;
  assign take    = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (rst)       idx <= '0;
    else if (take) idx <= idx + 1'b1;
  end

  cfg_hdr_fields #(
    .OFF_W(OFF_W), .LEN_POS(LEN_POS), .CNT_POS(CNT_POS), .MIN_HDR(MIN_HDR)
  ) u_fields (
    .clk(clk), .rst(rst), .take(take), .data(s_data), .idx(idx),
    .base_len(base_len), .base_good(base_good), .base_bad(base_bad),
    .comp_cnt(comp_cnt), .cnt_ok(cnt_ok)
  );

  cfg_lut_scan #(
    .OFF_W(OFF_W), .REC_BYTES(REC_BYTES), .ID_BS(ID_BS), .ID_TBL(ID_TBL)
  ) u_scan (
    .clk(clk), .rst(rst), .take(take), .data(s_data), .idx(idx),
    .base_len(base_len), .base_good(base_good), .state(scan_st),
    .bs_off(bs_off), .tbl_off(tbl_off), .tbl_known(tbl_known), .tbl_bad(tbl_bad)
  );

  cfg_size_unpack #(
    .OFF_W(OFF_W), .SIZE_W(SIZE_W), .SUM_W(SUM_W)
  ) u_unpack (
    .clk(clk), .rst(rst), .take(take), .data(s_data), .idx(idx),
    .tbl_known(tbl_known), .tbl_off(tbl_off), .comp_cnt(comp_cnt),
    .cnt_ok(cnt_ok), .sum(sum), .complete(complete)
  );

  assign err_now  = base_bad || (scan_st == SC_MISS) || tbl_bad;
  assign done_now = (scan_st == SC_HIT) && complete;

  always_ff @(posedge clk) begin
    if (rst) begin
      fin         <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
      bs_start    <= '0;
      payload_len <= '0;
    end else begin
      done <= 1'b0;
      if (!fin) begin
        if (err_now) begin
          err <= 1'b1;
          fin <= 1'b1;
        end else if (done_now) begin
          done        <= 1'b1;
          fin         <= 1'b1;
          bs_start    <= bs_off;
          payload_len <= {sum, {FRAME_LOG2{1'b0}}};
        end
      end
    end
  end

endmodule

// File: rtl/cfg_hdr_parser_chk.sv
module cfg_hdr_parser_chk #(
  parameter int OFF_W = 32,
  parameter int LEN_W = 44
) (
  input logic             clk,
  input logic             rst,
  input logic             s_ready,
  input logic             done,
  input logic             err,
  input logic [OFF_W-1:0] bs_start,
  input logic [LEN_W-1:0] payload_len
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (s_ready && !done && !err)); // R1

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_DONE_STOPS_INPUT: assert property (@(posedge clk) disable iff (rst)
    done |-> !s_ready); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> (err && !s_ready)); // R11

  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    err |-> !done); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!s_ready && !done) |-> ($stable(bs_start) && $stable(payload_len))); // R11

endmodule

bind cfg_hdr_parser cfg_hdr_parser_chk #(.OFF_W(OFF_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .s_ready(s_ready), .done(done), .err(err),
  .bs_start(bs_start), .payload_len(payload_len)
);

// File: tb/cfg_hdr_parser_test.sv
`timescale 1ns/1ps
module cfg_hdr_parser_test;

  localparam int IMG_N = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_valid = 1'b0;
  logic [7:0]  s_data = 8'h00;
  logic        s_ready, done, err;
  logic [31:0] bs_start;
  logic [43:0] payload_len;

  logic [7:0]  img [IMG_N];
  logic [21:0] sz  [16];
  longint      exp_sum;
  int          n_chk = 0, n_fail = 0, done_cnt = 0;

  always #2.5 clk = ~clk;

  cfg_hdr_parser uut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .bs_start(bs_start), .payload_len(payload_len), .done(done), .err(err)
  );

  always @(posedge clk) begin
    if (rst)       done_cnt <= 0;
    else if (done) done_cnt <= done_cnt + 1;
  end

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < IMG_N; i++) img[i] = 8'h00;
    exp_sum = 0;
  endtask

  task automatic set_hdr(int base, int nrec, int cnt);
    img[24] = 8'(base);
    if (base > 0) img[base-1] = 8'(nrec);
    img[55] = 8'(cnt);
    img[56] = 8'(cnt >> 8);
  endtask

  task automatic put_rec(int base, int k, int id, logic [31:0] start);
    int at = base + 9 * k;
    img[at]   = 8'(id);
    img[at+1] = start[7:0];
    img[at+2] = start[15:8];
    img[at+3] = start[23:16];
    img[at+4] = start[31:24];
  endtask

  task automatic put_sizes(int tbl, int cnt);
    for (int i = 0; i < cnt; i++) begin
      exp_sum += longint'(sz[i]);
      for (int b = 0; b < 22; b++) begin
        int p = 22 * i + b;
        img[tbl + p / 8][p % 8] = sz[i][b];
      end
    end
  endtask

  task automatic do_reset();
    s_valid = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic run(int n);
    int i = 0;
    do_reset();
    while (i < n && done_cnt == 0 && !err) begin
      if (s_ready) begin
        s_valid = 1'b1;
        s_data  = img[i];
        i++;
      end else begin
        s_valid = 1'b0;
      end
      @(negedge clk);
    end
    s_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_done(string req, logic [31:0] bs);
    check(req, "done pulses", 64'(done_cnt), 64'd1);
    check(req, "err", 64'(err), 64'd0);
    check(req, "bs_start", 64'(bs_start), 64'(bs));
    check(req, "payload_len", 64'(payload_len), 64'(exp_sum * 16));
    check("R11", "s_ready after done", 64'(s_ready), 64'd0);
  endtask

  task automatic expect_err(string req);
    check(req, "err", 64'(err), 64'd1);
    check(req, "done pulses", 64'(done_cnt), 64'd0);
    check(req, "bs_start", 64'(bs_start), 64'd0);
    check("R11", "s_ready after err", 64'(s_ready), 64'd0);
  endtask

  // R1
  task automatic t_reset();
    do_reset();
    check("R1", "s_ready", 64'(s_ready), 64'd1);
    check("R1", "done", 64'(done), 64'd0);
    check("R1", "err", 64'(err), 64'd0);
    check("R1", "bs_start", 64'(bs_start), 64'd0);
    check("R1", "payload_len", 64'(payload_len), 64'd0);
  endtask

  // R2 R3 R4 R5 R8: base 80, ignored ID first, then size table and bitstream
  task automatic t_basic();
    clear_img();
    set_hdr(80, 3, 3);
    put_rec(80, 0, 3, 32'd999);
    put_rec(80, 1, 5, 32'd120);
    put_rec(80, 2, 8, 32'd200);
    sz[0] = 22'h3FFFFF; sz[1] = 22'h000001; sz[2] = 22'h012345;
    put_sizes(120, 3);
    run(300);
    expect_done("R4", 32'd200);
    check("R8", "err after 3 sizes", 64'(err), 64'd0);
  endtask

  // R6: records after both offsets are known are not read
  task automatic t_stop();
    clear_img();
    set_hdr(71, 4, 2);
    put_rec(71, 0, 8, 32'd300);
    put_rec(71, 1, 5, 32'd110);
    put_rec(71, 2, 8, 32'd777);
    put_rec(71, 3, 8, 32'd888);
    sz[0] = 22'd5; sz[1] = 22'd7;
    put_sizes(110, 2);
    run(400);
    expect_done("R6", 32'd300);
  endtask

  // R12: a repeated ID before the walk ends replaces the offset
  task automatic t_dup();
    clear_img();
    set_hdr(75, 3, 1);
    put_rec(75, 0, 8, 32'd400);
    put_rec(75, 1, 8, 32'd500);
    put_rec(75, 2, 5, 32'd130);
    sz[0] = 22'h2AAAAA;
    put_sizes(130, 1);
    run(400);
    expect_done("R12", 32'd500);
  endtask

  // R7: no size-table record
  task automatic t_missing();
    clear_img();
    set_hdr(72, 2, 1);
    put_rec(72, 0, 8, 32'd200);
    put_rec(72, 1, 3, 32'd150);
    run(300);
    expect_err("R7");
  endtask

  // R3: zero records
  task automatic t_zero_rec();
    clear_img();
    set_hdr(71, 0, 1);
    run(300);
    expect_err("R3");
  endtask

  // R2: base length one below the minimum
  task automatic t_short();
    clear_img();
    set_hdr(70, 2, 0);
    put_rec(70, 0, 5, 32'd100);
    put_rec(70, 1, 8, 32'd150);
    run(300);
    expect_err("R2");
  endtask

  // R9: zero components
  task automatic t_cnt0();
    clear_img();
    set_hdr(71, 2, 0);
    put_rec(71, 0, 5, 32'd100);
    put_rec(71, 1, 8, 32'd150);
    run(300);
    expect_done("R9", 32'd150);
    check("R9", "zero length", 64'(payload_len), 64'd0);
  endtask

  // R10: the table offset equals the index of its record's last offset byte (75)
  task automatic t_tbl_bad();
    clear_img();
    set_hdr(71, 2, 1);
    put_rec(71, 0, 5, 32'd75);
    put_rec(71, 1, 8, 32'd200);
    run(300);
    expect_err("R10");
  endtask

  // R10: the table offset is one past that index
  task automatic t_tbl_edge();
    clear_img();
    set_hdr(71, 2, 1);
    put_rec(71, 0, 5, 32'd76);
    sz[0] = 22'h1ABCDE;
    put_sizes(76, 1);
    put_rec(71, 1, 8, 32'd210);
    run(300);
    expect_done("R10", 32'd210);
  endtask

  // R8: ten sizes covering every bit phase
  task automatic t_many();
    clear_img();
    set_hdr(71, 2, 10);
    put_rec(71, 0, 8, 32'd400);
    put_rec(71, 1, 5, 32'd90);
    for (int i = 0; i < 10; i++)
      sz[i] = 22'(((i + 1) * 32'h0001F3A7) ^ (i << 15));
    put_sizes(90, 10);
    run(450);
    expect_done("R8", 32'd400);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_stop();
    t_dup();
    t_missing();
    t_zero_rec();
    t_short();
    t_cnt0();
    t_tbl_bad();
    t_tbl_edge();
    t_many();
    summary();
    $finish;
  end

endmodule